// File: doc/BRIEF.md
# Serial Memory Status Register and Write Guard

This block keeps the one-byte status register of a byte-addressed serial memory. It also decides, every cycle, whether a memory write to the presented byte address may go ahead and whether a status write may go ahead. A command decoder in front of it sends single-cycle strobes: latch set, latch clear, status write with its data byte, end of a memory write, and start of a transaction. The block also takes the active-low hardware lock pin and the target byte address.

Protection works in layers. The write-enable latch must be set before any write. It drops again after every write. A two-bit range field shields none of the array, its top quarter, its top half or all of it. A guard bit decides whether the hardware lock pin is allowed to freeze the status register. The guard bit and the range field stand in for nonvolatile storage. They power up from a parameter and survive the synchronous reset. The reset clears only the latch and the captured pin state.

Top module: `wprot_status_unit`

## Requirements
- R1: The status byte has bit 7 = guard bit, bit 6 = constant 1, bits 5:4 = constant 0, bits 3:2 = range field, bit 1 = write-enable latch and bit 0 = constant 0. After power-up the guard bit and range field hold `NV_INIT`; the default of 0 gives a status byte of 0x40.
- R2: A latch-set strobe sets bit 1 at the next clock edge. A latch-clear strobe clears it. When both arrive in the same cycle, the clear wins.
- R3: An end-of-memory-write strobe clears the latch. Any status-write strobe clears the latch too, whether or not the status write was permitted. Either clear wins over a set in the same cycle.
- R4: The range field decodes as follows: 00 shields nothing, 01 shields the top quarter of the address space (0x30000–0x3FFFF at 18 bits), 10 shields the top half (0x20000–0x3FFFF), and 11 shields every address.
- R5: The memory-write permit is high only when the latch is 1 and the presented address is not shielded.
- R6: The status-write permit is high only when the latch is 1 and the captured lock pin is not low with the guard bit at 1. When the guard bit is 0, the pin has no influence.
- R7: A permitted status write loads data bits 7, 3 and 2 into the guard bit and range field. Data bits 6, 5, 4, 1 and 0 have no effect. A status write that is not permitted leaves the guard bit and range field unchanged.
- R8: The lock pin is captured only on a transaction-start strobe. Pin changes between starts do not affect the status-write permit until the next start.
- R9: The synchronous reset clears the latch and sets the captured pin to low (locked). It leaves the guard bit and range field unchanged.
- R10: With range 11, the guard bit at 1 and a low pin captured, no memory address and no status write can be permitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (latch and pin capture only) |
| set_en_i | input | 1 | Latch-set command strobe |
| clr_en_i | input | 1 | Latch-clear command strobe |
| st_wr_i | input | 1 | Status-write command strobe |
| st_data_i | input | 8 | Data byte of the status write |
| mem_done_i | input | 1 | End of a memory write |
| txn_start_i | input | 1 | Transaction start; captures the lock pin |
| lock_n_i | input | 1 | Active-low hardware lock pin |
| addr_i | input | ADDR_W | Target byte address |
| status_o | output | 8 | Status byte for readback |
| mem_wr_ok_o | output | 1 | Memory write permitted at addr_i |
| st_wr_ok_o | output | 1 | Status write permitted |

## Verification
The hardest state to reach is a pin capture that disagrees with the live pin while the guard bit is set. This needs a start strobe with the pin high, then the pin dropped with no new start, then a fresh latch set and a status write. The directed sequence builds that case on purpose. It also builds the mirror case, where a low pin is captured and then raised. A long random phase follows. It mixes every strobe, including same-cycle set/clear/write collisions and rare resets, against a behavioural model checked on every cycle.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

    typedef enum logic [1:0] {
        RANGE_NONE = 2'b00,
        RANGE_QTR  = 2'b01,
        RANGE_HALF = 2'b10,
        RANGE_ALL  = 2'b11
    } range_e;

    typedef struct packed {
        logic   guard;
        range_e rng;
    } nv_t;

    localparam int GUARD_POS = 7;
    localparam int RNG_HI    = 3;
    localparam int RNG_LO    = 2;

    // true when an address whose top two bits are 'top' is shielded
    function automatic logic range_hit(range_e r, logic [1:0] top);
        case (r)
            RANGE_NONE: return 1'b0;
            RANGE_QTR:  return (top == 2'b11);
            RANGE_HALF: return top[1];
            default:    return 1'b1;
        endcase
    endfunction

    function automatic logic [7:0] pack_status(nv_t nv, logic lat);
        return {nv.guard, 1'b1, 2'b00, nv.rng, lat, 1'b0};
    endfunction

    function automatic nv_t unpack_nv(logic [7:0] d);
        nv_t n;
        n.guard = d[GUARD_POS];
        n.rng   = range_e'(d[RNG_HI:RNG_LO]);
        return n;
    endfunction

endpackage

// File: rtl/wprot_latch.sv
module wprot_latch (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    logic q;

    always_ff @(posedge clk) begin
        if (rst)        q <= 1'b0;
        else if (clr_i) q <= 1'b0;
        else if (set_i) q <= 1'b1;
    end

    assign q_o = q;
endmodule

// File: rtl/wprot_nv.sv
module wprot_nv
    import wprot_pkg::*;
#(
    parameter logic [2:0] NV_INIT = 3'b000
) (
    input  logic       clk,
    input  logic       we_i,
    input  logic [7:0] data_i,
    output nv_t        nv_o
);
    // power-up value only; no reset input imitates nonvolatile cells
    nv_t nv_q = nv_t'(NV_INIT);

    always_ff @(posedge clk) begin
        if (we_i) nv_q <= unpack_nv(data_i);
    end

    assign nv_o = nv_q;
endmodule

// File: rtl/wprot_pin_snap.sv
module wprot_pin_snap (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic pin_n_i,
    output logic snap_n_o
);
    logic snap;

    always_ff @(posedge clk) begin
        if (rst)          snap <= 1'b0;
        else if (start_i) snap <= pin_n_i;
    end

    assign snap_n_o = snap;
endmodule

// File: rtl/wprot_status_unit.sv
module wprot_status_unit
    import wprot_pkg::*;
#(
    parameter int         ADDR_W  = 18,
    parameter logic [2:0] NV_INIT = 3'b000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_en_i,
    input  logic              clr_en_i,
    input  logic              st_wr_i,
    input  logic [7:0]        st_data_i,
    input  logic              mem_done_i,
    input  logic              txn_start_i,
    input  logic              lock_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [7:0]        status_o,
    output logic              mem_wr_ok_o,
    output logic              st_wr_ok_o
);
    localparam int TOP_HI = ADDR_W - 1;

    logic lat;
    logic snap_n;
    nv_t  nv;
    logic lat_clr;
    logic st_ok;

    // any write activity drops the latch; clear beats set
    assign lat_clr = clr_en_i | st_wr_i | mem_done_i;

    wprot_latch u_latch (
        .clk   (clk),
        .rst   (rst),
        .set_i (set_en_i),
        .clr_i (lat_clr),
        .q_o   (lat)
    );

    wprot_pin_snap u_snap (
        .clk      (clk),
        .rst      (rst),
        .start_i  (txn_start_i),
        .pin_n_i  (lock_n_i),
        .snap_n_o (snap_n)
    );

    assign st_ok = lat & ~(nv.guard & ~snap_n);

    wprot_nv #(.NV_INIT(NV_INIT)) u_nv (
        .clk    (clk),
        .we_i   (st_wr_i & st_ok),
        .data_i (st_data_i),
        .nv_o   (nv)
    );

    assign mem_wr_ok_o = lat & ~range_hit(nv.rng, addr_i[TOP_HI -: 2]);
    assign st_wr_ok_o  = st_ok;
    assign status_o    = pack_status(nv, lat);
endmodule

// File: rtl/wprot_status_chk.sv
module wprot_status_chk #(
    parameter int ADDR_W = 18
) (
    input logic              clk,
    input logic              rst,
    input logic              set_en_i,
    input logic              clr_en_i,
    input logic              st_wr_i,
    input logic [7:0]        st_data_i,
    input logic              mem_done_i,
    input logic              txn_start_i,
    input logic              lock_n_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [7:0]        status_o,
    input logic              mem_wr_ok_o,
    input logic              st_wr_ok_o
);
    assert_fixed_bits_R1: assert property (@(posedge clk) disable iff (rst)
        (status_o[6] && status_o[5:4] == 2'b00 && !status_o[0]));

    assert_set_alone_R2: assert property (@(posedge clk) disable iff (rst)
        (set_en_i && !clr_en_i && !st_wr_i && !mem_done_i) |=> status_o[1]);

    assert_clear_R2: assert property (@(posedge clk) disable iff (rst)
        clr_en_i |=> !status_o[1]);

    assert_done_clears_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_done_i || st_wr_i) |=> !status_o[1]);

    assert_mem_needs_latch_R5: assert property (@(posedge clk) disable iff (rst)
        mem_wr_ok_o |-> status_o[1]);

    assert_st_needs_latch_R6: assert property (@(posedge clk) disable iff (rst)
        st_wr_ok_o |-> status_o[1]);

    assert_blocked_keeps_R7: assert property (@(posedge clk) disable iff (rst)
        (st_wr_i && !st_wr_ok_o) |=> $stable(status_o[7:2]));

    assert_all_shielded_R10: assert property (@(posedge clk) disable iff (rst)
        (status_o[3:2] == 2'b11) |-> !mem_wr_ok_o);
endmodule

bind wprot_status_unit wprot_status_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/wprot_status_unit_bench.sv
module wprot_status_unit_bench;
    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          set_en_i = 0, clr_en_i = 0, st_wr_i = 0, mem_done_i = 0;
    logic          txn_start_i = 0, lock_n_i = 1;
    logic [7:0]    st_data_i = 0;
    logic [AW-1:0] addr_i = 0;
    logic [7:0]    status_o;
    logic          mem_wr_ok_o, st_wr_ok_o;

    int checks = 0, errors = 0;
    bit finished = 0;

    // behavioural reference state
    int m_lat = 0, m_guard = 0, m_rng = 0, m_snap = 0;

    always #10 clk = ~clk;

    wprot_status_unit #(.ADDR_W(AW)) u_wprot_status_unit (.*);

    function automatic int exp_status();
        return m_guard * 128 + 64 + m_rng * 4 + m_lat * 2;
    endfunction

    function automatic int shielded(int a);
        int span = 1 << AW;
        case (m_rng)
            0: return 0;
            1: return (a >= (span / 4) * 3) ? 1 : 0;
            2: return (a >= span / 2) ? 1 : 0;
            default: return 1;
        endcase
    endfunction

    function automatic int exp_st_ok();
        if (m_lat == 0) return 0;
        if (m_guard == 1 && m_snap == 0) return 0;
        return 1;
    endfunction

    function automatic int exp_mem_ok();
        return (m_lat == 1 && shielded(int'(addr_i)) == 0) ? 1 : 0;
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // drive one cycle, compare before the edge, then advance the model
    task automatic step(bit r, bit s, bit c, bit w, bit [7:0] d, bit dn,
                        bit st, bit pin, int a, string tag);
        int okw;
        @(negedge clk);
        rst = r; set_en_i = s; clr_en_i = c; st_wr_i = w; st_data_i = d;
        mem_done_i = dn; txn_start_i = st; lock_n_i = pin; addr_i = a[AW-1:0];
        #2;
        if (!r) begin
            chk({tag, " status"}, int'(status_o), exp_status());
            chk({tag, " mem_ok"}, int'(mem_wr_ok_o), exp_mem_ok());
            chk({tag, " st_ok"}, int'(st_wr_ok_o), exp_st_ok());
        end
        okw = exp_st_ok();
        @(posedge clk);
        if (r) begin
            m_lat = 0; m_snap = 0;
        end else begin
            if (st) m_snap = pin;
            if (w && okw == 1) begin
                m_guard = d[7]; m_rng = d[3:2];
            end
            if (c || w || dn) m_lat = 0;
            else if (s) m_lat = 1;
        end
    endtask

    task automatic idle(bit pin, int a, string tag);
        step(0, 0, 0, 0, 8'h00, 0, 0, pin, a, tag);
    endtask

    initial begin
        step(1, 0, 0, 0, 0, 0, 0, 1, 0, "R9");
        step(1, 0, 0, 0, 0, 0, 0, 1, 0, "R9");
        idle(1, 0, "R1 reset");                       // expect 0x40
        step(0, 1, 0, 0, 0, 0, 0, 1, 'h3FFFF, "R2 set");
        idle(1, 'h3FFFF, "R5 open range");
        step(0, 0, 0, 0, 0, 0, 1, 1, 0, "R8 capture high");
        step(0, 0, 0, 1, 8'hBF, 0, 0, 1, 0, "R7 write guard+all"); // -> 0xCC
        idle(1, 0, "R3 latch dropped");
        step(0, 1, 0, 0, 0, 0, 1, 0, 0, "R10 capture low");
        idle(0, 'h00000, "R10 locked");
        step(0, 0, 0, 1, 8'h00, 0, 0, 0, 0, "R7 blocked write");
        idle(1, 0, "R3 blocked still clears");
        step(0, 1, 0, 0, 0, 0, 0, 1, 0, "R8 pin high no start");
        idle(1, 'h12345, "R8 still locked");
        step(0, 0, 0, 0, 0, 0, 1, 1, 0, "R8 recapture high");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R8 pin low mid txn");
        step(0, 0, 0, 1, 8'h84, 0, 0, 0, 0, "R6 write quarter"); // -> 0xC4
        step(0, 1, 0, 0, 0, 0, 0, 0, 0, "R2");
        idle(0, 'h2FFFF, "R4 below quarter");
        idle(0, 'h30000, "R4 quarter edge");
        step(0, 0, 0, 0, 0, 1, 0, 0, 'h1000, "R3 mem done");
        idle(0, 'h1000, "R3");
        step(0, 1, 0, 0, 0, 0, 1, 1, 0, "R6");
        step(0, 0, 0, 1, 8'h0B, 0, 0, 1, 0, "R7 half no guard"); // -> 0x48
        step(0, 1, 0, 0, 0, 0, 1, 0, 0, "R6 pin ignored");
        idle(0, 'h1FFFF, "R4 below half");
        idle(0, 'h20000, "R4 half edge");
        step(0, 1, 1, 0, 0, 0, 0, 0, 0, "R2 clear wins");
        idle(0, 0, "R2");
        step(0, 1, 0, 0, 0, 1, 0, 0, 0, "R3 done beats set");
        idle(0, 0, "R3");
        step(0, 1, 0, 0, 0, 0, 0, 1, 0, "R2");
        step(1, 0, 0, 0, 0, 0, 0, 1, 0, "R9");
        idle(1, 0, "R9 keeps range");
        for (int i = 0; i < 3000; i++) begin
            step(($urandom_range(0, 59) == 0), ($urandom_range(0, 2) == 0),
                 ($urandom_range(0, 7) == 0), ($urandom_range(0, 5) == 0),
                 8'($urandom), ($urandom_range(0, 7) == 0),
                 ($urandom_range(0, 4) == 0), 1'($urandom),
                 int'($urandom & 32'h3FFFF), "R5 random");
        end
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule